// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns two asynchronous interrupt pins into interrupt requests for a processor core. Each pin is brought into the system clock domain by a short flop chain. The sampled value is then read in one of three ways: as a low level, as a falling transition or as a rising transition. A fourth setting is reserved and stays silent. A two-bit sense field for each pin selects the reading. The fields for both pins sit together in one configuration word. A second configuration word holds one mask bit per pin.

Level detection gives a request that follows the sampled pin directly. Transition detection sets a sticky pending flag. The flag holds until software acknowledges it or until that pin's sense field is changed. A request is visible on the output only while the global enable input is high and the pin's mask bit is set. A pending flag survives a period of being masked, so its request appears as soon as the gate opens again. The reset input is asynchronous and active low, and its release is synchronized inside the block.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, irq_req is all zero, every sense field reads 00 (low-level) and every mask bit is 0. With the global enable and the masks then set and the pins high, no request appears. A low pin then raises its request.
- R2: With sense code 00, irq_req[i] becomes 1 two clock edges after pin_in[i] goes low. It stays 1 while the pin is low. It returns to 0 two edges after the pin goes high. Nothing is latched.
- R3: Sense code 01 is reserved. It never produces a request, whatever the pin does.
- R4: With sense code 10, a high-to-low transition of the sampled pin sets the pending flag three edges after the pin changes. The request then stays up until that pin is acknowledged, even after the pin returns high.
- R5: With sense code 11, a low-to-high transition of the sampled pin sets the pending flag three edges after the pin changes. It is held in the same way as in R4.
- R6: irq_req[i] is 1 only while glb_en is 1 and mask bit i is 1. A pending flag set while gated is kept. Its request appears as soon as both gates are open again.
- R7: A one-cycle pulse on irq_ack[i] clears pin i's pending flag. If a new matching transition is detected in the same cycle as the acknowledge, the flag stays set.
- R8: A write that changes pin i's sense field clears its pending flag, and no transition is reported across the change. A write that stores the same value again leaves the flag unchanged.
- R9: In transition mode, a pin level held across at least one rising clock edge is caught. A one-cycle low pulse is enough.
- R10: The two pins behave independently. The sense field for pin i is cfg_wdata[2i+1:2i], written with cfg_sel=0. The mask for pin i is cfg_wdata[i], written with cfg_sel=1. Writes take effect at the clock edge on which cfg_we is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects the sense word, 1 selects the mask word |
| cfg_wdata | input | 4 | Write data (2 bits per pin for sense, 1 bit per pin for mask) |
| glb_en | input | 1 | Global interrupt enable |
| pin_in | input | 2 | Asynchronous interrupt pins |
| irq_ack | input | 2 | Per-pin acknowledge, clears the pending transition flag |
| irq_req | output | 2 | Per-pin gated interrupt request |

## Verification
A stuck or wrongly cleared pending flag shows up directly on irq_req one edge after the event that should have changed it: an acknowledge, a sense rewrite or a detected transition. A missing synchronizer stage, or an extra one, moves the level and transition responses by one cycle, so the exact-cycle sampling at two and three edges exposes it at once. The sweep covers every sense code, enable value and mask value on each pin, so a wrong decode of any code or of any field position changes the request within three cycles of the pin toggle.

// File: rtl/eis_pkg.sv
package eis_pkg;

  localparam int SENSE_W = 2;

  typedef enum logic [SENSE_W-1:0] {
    SNS_LOW  = 2'b00,
    SNS_RSVD = 2'b01,
    SNS_FALL = 2'b10,
    SNS_RISE = 2'b11
  } sense_e;

endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/eis_cfg_regs.sv
module eis_cfg_regs
  import eis_pkg::*;
#(
  parameter int N_PINS = 2,
  localparam int CFG_W = SENSE_W * N_PINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  sense_o,
  output logic [N_PINS-1:0] mask_o,
  output logic [N_PINS-1:0] chg_o
);

  logic [CFG_W-1:0]  sense_q, sense_d;
  logic [N_PINS-1:0] mask_q, mask_d;
  logic              sense_wr, mask_wr;

  always_comb begin
    sense_wr = cfg_we && !cfg_sel;
    mask_wr  = cfg_we &&  cfg_sel;
    sense_d  = sense_q;
    mask_d   = mask_q;
    if (sense_wr) sense_d = cfg_wdata;
    if (mask_wr)  mask_d  = cfg_wdata[N_PINS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      mask_q  <= '0;
    end else begin
      if (sense_wr) sense_q <= sense_d;
      if (mask_wr)  mask_q  <= mask_d;
    end
  end

  for (genvar i = 0; i < N_PINS; i++) begin : g_chg
    assign chg_o[i] = sense_wr &&
      (cfg_wdata[SENSE_W*i +: SENSE_W] != sense_q[SENSE_W*i +: SENSE_W]);
  end

  assign sense_o = sense_q;
  assign mask_o  = mask_q;

  // R10: a mask write takes effect on the next cycle
  p_mask_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_o == $past(cfg_wdata[N_PINS-1:0])));

endmodule

// File: rtl/eis_pin_detect.sv
module eis_pin_detect
  import eis_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pin_async,
  input  logic [SENSE_W-1:0] sense,
  input  logic               sense_chg,
  input  logic               ack,
  output logic               req_raw
);

  logic   cur;
  logic   prev_q;
  logic   pend_q, pend_d, pend_en;
  logic   fall_hit, rise_hit, edge_hit;
  sense_e mode;

  eis_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_async),
    .q     (cur)
  );

  always_comb begin
    mode     = sense_e'(sense);
    fall_hit = prev_q && !cur;
    rise_hit = !prev_q && cur;
    case (mode)
      SNS_FALL: edge_hit = fall_hit;
      SNS_RISE: edge_hit = rise_hit;
      default:  edge_hit = 1'b0;
    endcase
  end

  always_comb begin
    pend_en = sense_chg || edge_hit || ack;
    if (sense_chg)     pend_d = 1'b0;
    else if (edge_hit) pend_d = 1'b1;
    else               pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= cur;
      if (pend_en) pend_q <= pend_d;
    end
  end

  always_comb begin
    case (mode)
      SNS_LOW:  req_raw = !cur;
      SNS_RSVD: req_raw = 1'b0;
      default:  req_raw = pend_q;
    endcase
  end

  // R8: a sense change always leaves the pending flag clear
  p_chg_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sense_chg |=> !pend_q);

  // R7: a detected transition beats a simultaneous acknowledge
  p_edge_beats_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit && !sense_chg) |=> pend_q);

  // R7: an acknowledge with no new transition clears the flag
  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !edge_hit && !sense_chg) |=> !pend_q);

  // R4: a pending flag is held until something clears it
  p_pend_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ack && !sense_chg) |=> pend_q);

  // R3: the reserved code never requests
  p_rsvd_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == SNS_RSVD) |-> !req_raw);

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import eis_pkg::*;
#(
  parameter int N_PINS      = 2,
  parameter int SYNC_STAGES = 2,
  localparam int CFG_W      = SENSE_W * N_PINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              glb_en,
  input  logic [N_PINS-1:0] pin_in,
  input  logic [N_PINS-1:0] irq_ack,
  output logic [N_PINS-1:0] irq_req
);

  logic              rst_n_int;
  logic [CFG_W-1:0]  sense_all;
  logic [N_PINS-1:0] mask_all;
  logic [N_PINS-1:0] chg_all;
  logic [N_PINS-1:0] raw_all;

  eis_sync #(.STAGES(2)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_n_int)
  );

  eis_cfg_regs #(.N_PINS(N_PINS)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .sense_o   (sense_all),
    .mask_o    (mask_all),
    .chg_o     (chg_all)
  );

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    eis_pin_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det (
      .clk       (clk),
      .rst_n     (rst_n_int),
      .pin_async (pin_in[i]),
      .sense     (sense_all[SENSE_W*i +: SENSE_W]),
      .sense_chg (chg_all[i]),
      .ack       (irq_ack[i]),
      .req_raw   (raw_all[i])
    );
  end

  assign irq_req = raw_all & mask_all & {N_PINS{glb_en}};

  // R6: clearing every mask bit silences all requests on the next cycle
  p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cfg_we && cfg_sel && (cfg_wdata[N_PINS-1:0] == '0)) |=> (irq_req == '0));

  // R1: no request during the first cycle after reset release
  p_reset_quiet_r1: assert property (@(posedge clk)
    $rose(rst_n_int) |-> (irq_req == '0));

endmodule

// File: tb/ext_irq_sense_tb.sv
module ext_irq_sense_tb;

  localparam int N = 2;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cfg_we, cfg_sel, glb_en;
  logic [2*N-1:0] cfg_wdata;
  logic [N-1:0] pin_in, irq_ack, irq_req;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  ext_irq_sense u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .glb_en(glb_en), .pin_in(pin_in),
    .irq_ack(irq_ack), .irq_req(irq_req)
  );

  task automatic check(input string req, input logic [N-1:0] exp);
    n_chk++;
    if (irq_req !== exp) begin
      n_err++;
      $display("FAIL %s: irq_req=%b expected %b at %0t", req, irq_req, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(input logic sel, input logic [2*N-1:0] data);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic ack_pulse(input logic [N-1:0] m);
    irq_ack = m;
    @(negedge clk);
    irq_ack = '0;
  endtask

  function automatic string tag(input int code);
    case (code)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    glb_en = 1'b0; pin_in = '1; irq_ack = '0;
    tick(3);
    check("R1 in reset", 2'b00);
    rst_n = 1'b1;
    tick(4);
    check("R1 after release", 2'b00);
    glb_en = 1'b1;
    wr_cfg(1'b1, 4'b0011);
    tick(2);
    check("R1 default low-level, pins high", 2'b00);
    pin_in[0] = 1'b0;
    tick(2);
    check("R1 default sense is low-level", 2'b01);
    pin_in[0] = 1'b1;
    tick(2);
    check("R2 level drops after pin high", 2'b00);

    // sweep: every pin, code, enable and mask
    for (int p = 0; p < N; p++) begin
      for (int code = 0; code < 4; code++) begin
        for (int en = 0; en < 2; en++) begin
          for (int m = 0; m < 2; m++) begin
            logic [N-1:0] bit_p;
            logic g;
            bit_p = '0; bit_p[p] = 1'b1;
            g = (en == 1) && (m == 1);
            wr_cfg(1'b0, 4'(code) << (2 * p));
            wr_cfg(1'b1, m ? bit_p : '0);
            glb_en = en[0];
            pin_in = '1;
            tick(3);
            ack_pulse('1);
            tick(1);
            check({tag(code), " R6 R10 idle"}, '0);
            pin_in[p] = 1'b0;
            tick(1);
            check({tag(code), " one-edge latency"}, '0);
            tick(1);
            check({tag(code), " low level at 2 edges"}, (g && code == 0) ? bit_p : '0);
            tick(1);
            check({tag(code), " fall at 3 edges"},
                  (g && (code == 0 || code == 2)) ? bit_p : '0);
            tick(2);
            check({tag(code), " held low"},
                  (g && (code == 0 || code == 2)) ? bit_p : '0);
            pin_in[p] = 1'b1;
            tick(2);
            check({tag(code), " pin high at 2 edges"}, (g && code == 2) ? bit_p : '0);
            tick(1);
            check({tag(code), " rise at 3 edges"}, (g && code >= 2) ? bit_p : '0);
            ack_pulse(bit_p);
            check({tag(code), " R7 after ack"}, '0);
          end
        end
      end
    end

    // R6: pending kept while masked
    glb_en = 1'b1; pin_in = '1;
    wr_cfg(1'b0, 4'b0010);
    wr_cfg(1'b1, 4'b0000);
    tick(3); ack_pulse('1);
    pin_in[0] = 1'b0; tick(1); pin_in[0] = 1'b1; tick(4);
    check("R6 masked pending hidden", 2'b00);
    wr_cfg(1'b1, 4'b0001);
    check("R6 unmask shows pending", 2'b01);
    glb_en = 1'b0; #1;
    check("R6 global enable low", 2'b00);
    tick(1); glb_en = 1'b1; #1;
    check("R6 global enable restored", 2'b01);

    // R9: one-cycle pulse already caught above; explicit single-cycle low pulse
    tick(1); ack_pulse(2'b01);
    check("R9 cleared before pulse", 2'b00);
    pin_in[0] = 1'b0; tick(1); pin_in[0] = 1'b1;
    tick(2);
    check("R9 one-cycle pulse caught", 2'b01);

    // R8: rewrite same value keeps flag, change clears it, no false edge
    wr_cfg(1'b0, 4'b0010);
    check("R8 same-value rewrite keeps pending", 2'b01);
    wr_cfg(1'b0, 4'b0011);
    check("R8 sense change clears pending", 2'b00);
    tick(3);
    check("R8 no false edge after change", 2'b00);

    // R7: transition and acknowledge in the same cycle
    pin_in[0] = 1'b0; tick(4);
    pin_in[0] = 1'b1; tick(3);
    check("R7 rise pending", 2'b01);
    pin_in[0] = 1'b0; tick(3);
    pin_in[0] = 1'b1; tick(2);
    irq_ack = 2'b01; tick(1); irq_ack = '0;
    check("R7 new edge beats ack", 2'b01);
    ack_pulse(2'b01);
    check("R7 plain ack clears", 2'b00);

    // R10: two pins in different modes together
    wr_cfg(1'b0, 4'b1100);
    wr_cfg(1'b1, 4'b0011);
    pin_in = 2'b01; tick(3); ack_pulse('1);
    check("R10 both idle", 2'b00);
    pin_in = 2'b10; tick(2);
    check("R10 pin0 level only", 2'b01);
    tick(1);
    check("R10 pin1 rise joins", 2'b11);
    pin_in[0] = 1'b1; tick(2);
    check("R10 pin0 drops pin1 held", 2'b10);
    ack_pulse(2'b10);
    check("R10 pin1 acked", 2'b00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule